// File: doc/BRIEF.md
# Left-Right Disparity Consistency Filter

This block cleans a disparity stream by comparing two estimates of the same scanline. One estimate is referenced to the right image and arrives in natural pixel order. The other is referenced to the left image. It was produced on a mirrored scanline, so it arrives last pixel first. Both streams share one valid strobe and one start-of-line marker, one pixel per valid cycle. Every line holds exactly `LINE_W` valid pixels.

A ping-pong line store brings both streams into the same order and phase. It writes one line while it reads back the line before it. The left lane is read back in reverse order and the right lane in forward order. A tapped delay window then holds the most recent left-referenced disparities of the line. For each right-referenced pixel, the window yields the left-referenced value at the position that pixel's disparity points to. Pixels whose two estimates agree pass unchanged. Pixels that disagree, typically at occlusions and bad matches, are replaced by the left-referenced disparity of the same position.

Top module: `lr_consistency_check`

## Requirements
- R1: While reset is high and in the first sampled cycle after it, `out_valid` and `out_sol` are 0.
- R2: Line k appears at the output while line k+1 is being input. Its pixel i is presented two clock edges after pixel i of line k+1 enters, and `out_valid` follows `in_valid` with the same gaps. The first line after reset produces no output.
- R3: Within each line, input position j of `in_ldisp_mir` carries the left-referenced disparity of pixel `LINE_W-1-j`.
- R4: For output pixel x with right-referenced disparity d, the reference value is the left-referenced disparity of pixel x-d of the same line.
- R5: If d is at most x and the reference value equals d, the output is d.
- R6: If d is at most x and the reference value differs from d, the output is the left-referenced disparity of pixel x.
- R7: If d is greater than x, so the reference would lie before the start of the line, the output is d.
- R8: `out_sol` is 1 exactly on output pixel 0 of each line, and only together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel strobe for both streams |
| in_sol | input | 1 | First pixel of a line, qualified by in_valid |
| in_rdisp | input | DISP_W | Right-referenced disparity, natural order |
| in_ldisp_mir | input | DISP_W | Left-referenced disparity, mirrored order |
| out_valid | output | 1 | Output pixel strobe |
| out_sol | output | 1 | First output pixel of a line |
| out_disp | output | DISP_W | Checked disparity |

## Verification
The two functions that collide are the bank swap of the line store and the restart of the lookup window. Both happen on the first pixel of a line. Lines are sent back to back, with no idle cycle, so the read bank flips and the reversed read address jumps to the top in the same cycle in which the window must forget the previous line. In that cycle a large disparity has to take the edge path and must not reach stale taps. The bench mixes disparities that are forced to agree, forced edge values, zero disparities and arbitrary values across many lines, with and without idle gaps. It judges every output slot, valid or idle, against an arithmetic model of the requirements.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    localparam int DISP_W_DEF = 5;
    localparam int LINE_W_DEF = 64;

    // stream framing markers travelling beside the data
    typedef struct packed {
        logic valid;
        logic sol;
    } mark_t;

    // which source feeds the output pixel
    typedef enum logic [1:0] {
        PICK_EDGE  = 2'd0,   // reference before line start: keep right value
        PICK_AGREE = 2'd1,   // both estimates agree
        PICK_FILL  = 2'd2    // disagreement: substitute left value
    } pick_e;

    function automatic pick_e choose_source(input logic reachable, input logic agree);
        if (!reachable)
            return PICK_EDGE;
        else if (agree)
            return PICK_AGREE;
        else
            return PICK_FILL;
    endfunction

    function automatic int width_for(input int count);
        return (count <= 2) ? 1 : $clog2(count);
    endfunction

endpackage

// File: rtl/lrc_line_pingpong.sv
module lrc_line_pingpong
    import lrc_pkg::*;
#(
    parameter int                LANE_W       = 5,
    parameter int                LANES        = 2,
    parameter int                LINE_W       = 64,
    parameter logic [LANES-1:0]  REVERSE_MASK = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  mark_t                    in_mark,
    input  logic [LANES*LANE_W-1:0]  in_data,
    output mark_t                    out_mark,
    output logic [LANES*LANE_W-1:0]  out_data
);

    localparam int AW    = width_for(LINE_W);
    localparam int DEPTH = 2 * LINE_W;
    localparam int IW    = width_for(DEPTH);

    logic          wr_bank;
    logic [AW-1:0] wr_ptr;
    logic          seen_any;
    logic          have_prev;

    logic          bank_now;
    logic [AW-1:0] ptr_now;
    logic          prev_now;
    logic [IW-1:0] wr_idx;

    always_comb begin
        bank_now = (in_mark.valid && in_mark.sol) ? ~wr_bank : wr_bank;
        ptr_now  = (in_mark.valid && in_mark.sol) ? '0 : wr_ptr;
        prev_now = (in_mark.valid && in_mark.sol) ? seen_any : have_prev;
        wr_idx   = IW'(ptr_now) + (bank_now ? IW'(LINE_W) : IW'(0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bank   <= 1'b0;
            wr_ptr    <= '0;
            seen_any  <= 1'b0;
            have_prev <= 1'b0;
            out_mark  <= '0;
        end else begin
            out_mark.valid <= in_mark.valid && prev_now;
            out_mark.sol   <= in_mark.valid && in_mark.sol && prev_now;
            if (in_mark.valid) begin
                wr_bank   <= bank_now;
                wr_ptr    <= AW'(ptr_now + 1'b1);
                seen_any  <= 1'b1;
                have_prev <= prev_now;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [AW-1:0]     rd_ptr;
        logic [IW-1:0]     rd_idx;

        if (REVERSE_MASK[g]) begin : g_rev
            // reading runs downward while writing runs upward
            assign rd_ptr = AW'(LINE_W - 1) - ptr_now;
        end else begin : g_fwd
            assign rd_ptr = ptr_now;
        end

        assign rd_idx = IW'(rd_ptr) + (bank_now ? IW'(0) : IW'(LINE_W));

        always_ff @(posedge clk) begin
            if (in_mark.valid)
                mem[wr_idx] <= in_data[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                out_data[g*LANE_W +: LANE_W] <= '0;
            else if (in_mark.valid)
                out_data[g*LANE_W +: LANE_W] <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/lrc_tap_window.sv
module lrc_tap_window
    import lrc_pkg::*;
#(
    parameter int DISP_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  mark_t             in_mark,
    input  logic [DISP_W-1:0] left_disp,
    input  logic [DISP_W-1:0] sel,
    output logic [DISP_W-1:0] tap_val,
    output logic              reachable
);

    localparam int TAPS   = (1 << DISP_W) - 1;
    localparam int POINTS = TAPS + 1;

    logic [DISP_W-1:0] sr   [TAPS];
    logic [DISP_W-1:0] tapv [POINTS];
    logic [DISP_W-1:0] cnt;
    logic [DISP_W-1:0] cnt_now;

    assign tapv[0] = left_disp;
    for (genvar k = 1; k < POINTS; k++) begin : g_tap
        assign tapv[k] = sr[k-1];
    end

    assign cnt_now   = in_mark.sol ? '0 : cnt;
    assign tap_val   = tapv[sel];
    assign reachable = (sel <= cnt_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (in_mark.valid) begin
            cnt <= (&cnt_now) ? cnt_now : DISP_W'(cnt_now + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (in_mark.valid) begin
            sr[0] <= left_disp;
            for (int k = 1; k < TAPS; k++)
                sr[k] <= sr[k-1];
        end
    end

endmodule

// File: rtl/lrc_decide.sv
module lrc_decide
    import lrc_pkg::*;
#(
    parameter int DISP_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  mark_t             in_mark,
    input  logic [DISP_W-1:0] right_disp,
    input  logic [DISP_W-1:0] left_disp,
    input  logic [DISP_W-1:0] tap_val,
    input  logic              reachable,
    output mark_t             out_mark,
    output logic [DISP_W-1:0] out_disp
);

    pick_e             pick;
    logic [DISP_W-1:0] chosen;

    always_comb begin
        pick = choose_source(reachable, tap_val == right_disp);
        case (pick)
            PICK_FILL: chosen = left_disp;
            default:   chosen = right_disp;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_mark <= '0;
            out_disp <= '0;
        end else begin
            out_mark <= in_mark;
            if (in_mark.valid)
                out_disp <= chosen;
        end
    end

endmodule

// File: rtl/lr_consistency_check.sv
module lr_consistency_check
    import lrc_pkg::*;
#(
    parameter int DISP_W = DISP_W_DEF,
    parameter int LINE_W = LINE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic [DISP_W-1:0] in_rdisp,
    input  logic [DISP_W-1:0] in_ldisp_mir,
    output logic              out_valid,
    output logic              out_sol,
    output logic [DISP_W-1:0] out_disp
);

    localparam int LANES = 2;   // lane 0: right stream, lane 1: left stream

    mark_t                    in_mark;
    mark_t                    algn_mark;
    mark_t                    dec_mark;
    logic [LANES*DISP_W-1:0]  packed_in;
    logic [LANES*DISP_W-1:0]  packed_out;

    logic                     algn_valid;
    logic [DISP_W-1:0]        algn_r;
    logic [DISP_W-1:0]        algn_l;
    logic [DISP_W-1:0]        tap_val;
    logic                     reachable;

    assign in_mark.valid = in_valid;
    assign in_mark.sol   = in_valid && in_sol;
    assign packed_in     = {in_ldisp_mir, in_rdisp};

    lrc_line_pingpong #(
        .LANE_W       (DISP_W),
        .LANES        (LANES),
        .LINE_W       (LINE_W),
        .REVERSE_MASK (2'b10)
    ) u_lines (
        .clk      (clk),
        .rst      (rst),
        .in_mark  (in_mark),
        .in_data  (packed_in),
        .out_mark (algn_mark),
        .out_data (packed_out)
    );

    assign algn_r     = packed_out[0 +: DISP_W];
    assign algn_l     = packed_out[DISP_W +: DISP_W];
    assign algn_valid = algn_mark.valid;

    lrc_tap_window #(
        .DISP_W (DISP_W)
    ) u_window (
        .clk       (clk),
        .rst       (rst),
        .in_mark   (algn_mark),
        .left_disp (algn_l),
        .sel       (algn_r),
        .tap_val   (tap_val),
        .reachable (reachable)
    );

    lrc_decide #(
        .DISP_W (DISP_W)
    ) u_decide (
        .clk        (clk),
        .rst        (rst),
        .in_mark    (algn_mark),
        .right_disp (algn_r),
        .left_disp  (algn_l),
        .tap_val    (tap_val),
        .reachable  (reachable),
        .out_mark   (dec_mark),
        .out_disp   (out_disp)
    );

    assign out_valid = dec_mark.valid;
    assign out_sol   = dec_mark.sol;

endmodule

// File: rtl/lr_consistency_check_sva.sv
module lr_consistency_check_sva #(
    parameter int DISP_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_sol,
    input logic              out_valid,
    input logic              out_sol,
    input logic [DISP_W-1:0] out_disp,
    input logic              algn_valid,
    input logic [DISP_W-1:0] algn_r,
    input logic [DISP_W-1:0] algn_l
);

    logic [1:0] lines_in;

    always_ff @(posedge clk) begin
        if (rst)
            lines_in <= '0;
        else if (in_valid && in_sol && lines_in != 2'd3)
            lines_in <= lines_in + 2'd1;
    end

    assert_sol_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> out_valid);

    assert_output_follows_input_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    assert_first_line_silent_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (lines_in >= 2'd2));

    assert_aligned_reaches_output_R2: assert property (@(posedge clk) disable iff (rst)
        algn_valid |=> out_valid);

    assert_source_is_right_or_left_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_disp == $past(algn_r) || out_disp == $past(algn_l)));

    assert_equal_inputs_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(algn_r) == $past(algn_l)) |-> out_disp == $past(algn_r));

endmodule

bind lr_consistency_check lr_consistency_check_sva #(.DISP_W(DISP_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sol     (in_sol),
    .out_valid  (out_valid),
    .out_sol    (out_sol),
    .out_disp   (out_disp),
    .algn_valid (algn_valid),
    .algn_r     (algn_r),
    .algn_l     (algn_l)
);

// File: tb/lr_consistency_check_tb_top.sv
module lr_consistency_check_tb_top;

    localparam int DW = 5;
    localparam int LW = 40;
    localparam int NL = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sol = 1'b0;
    logic [DW-1:0] in_rdisp = '0;
    logic [DW-1:0] in_ldisp_mir = '0;
    logic          out_valid;
    logic          out_sol;
    logic [DW-1:0] out_disp;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    int n_edge = 0, n_agree = 0, n_fill = 0;

    int Lm [2][LW];
    int Rm [2][LW];

    // expectation pipeline: stage 0 = driven now, stage 1 = due this cycle
    bit p0_v = 0, p0_s = 0, p1_v = 0, p1_s = 0;
    int p0_d = 0, p0_k = 0, p0_ln = 0, p0_px = 0;
    int p1_d = 0, p1_k = 0, p1_ln = 0, p1_px = 0;

    always #4 clk = ~clk;   // 125 MHz

    lr_consistency_check #(.DISP_W(DW), .LINE_W(LW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_sol       (in_sol),
        .in_rdisp     (in_rdisp),
        .in_ldisp_mir (in_ldisp_mir),
        .out_valid    (out_valid),
        .out_sol      (out_sol),
        .out_disp     (out_disp)
    );

    task automatic fail_line(input string req, input int act, input int exp, input int ln, input int px);
        mismatched++;
        $display("FAIL %s line %0d px %0d: actual %0d expected %0d", req, ln, px, act, exp);
    endtask

    task automatic judge();
        compared++;
        if (out_valid !== p1_v) begin
            fail_line("R2 valid", int'(out_valid), int'(p1_v), p1_ln, p1_px);
        end else if (p1_v) begin
            if (out_sol !== p1_s)
                fail_line("R8 sol", int'(out_sol), int'(p1_s), p1_ln, p1_px);
            else if (int'(out_disp) != p1_d) begin
                case (p1_k)
                    0: fail_line("R7 edge", int'(out_disp), p1_d, p1_ln, p1_px);
                    1: fail_line("R5 agree (R4 lookup)", int'(out_disp), p1_d, p1_ln, p1_px);
                    default: fail_line("R6 fill (R3 order)", int'(out_disp), p1_d, p1_ln, p1_px);
                endcase
            end
        end
    endtask

    task automatic cycle(input bit v, input bit s, input int r, input int lm,
                         input bit ev, input bit es, input int ed, input int ek,
                         input int ln, input int px);
        @(negedge clk);
        judge();
        p1_v = p0_v; p1_s = p0_s; p1_d = p0_d; p1_k = p0_k; p1_ln = p0_ln; p1_px = p0_px;
        p0_v = ev; p0_s = es; p0_d = ed; p0_k = ek; p0_ln = ln; p0_px = px;
        in_valid = v;
        in_sol = s;
        in_rdisp = DW'(r);
        in_ldisp_mir = DW'(lm);
    endtask

    task automatic build_line(input int k);
        int c = k % 2;
        for (int x = 0; x < LW; x++)
            Lm[c][x] = ((x >> 2) + k) % 12;
        for (int x = 0; x < LW; x++) begin
            int sel = (k * 13 + x * 7) % 4;
            case (sel)
                0: begin
                    int found = -1;
                    for (int d = (x < 31 ? x : 31); d >= 0; d--)
                        if (found < 0 && Lm[c][x-d] == d) found = d;
                    Rm[c][x] = (found >= 0) ? found : (x + k) % 32;
                end
                1: Rm[c][x] = (x * 11 + k * 5) % 32;
                2: Rm[c][x] = 31;
                default: Rm[c][x] = 0;
            endcase
        end
    endtask

    // R4..R7 model for pixel x of line p
    task automatic expect_px(input int p, input int x, output int ed, output int ek);
        int rr = Rm[p][x];
        if (rr > x) begin
            ed = rr; ek = 0;
        end else if (Lm[p][x-rr] == rr) begin
            ed = rr; ek = 1;
        end else begin
            ed = Lm[p][x]; ek = 2;
        end
    endtask

    task automatic send_line(input int k);
        int c = k % 2;
        int p = (k + 1) % 2;
        build_line(k);
        for (int x = 0; x < LW; x++) begin
            int ed, ek;
            bit ev;
            if (k % 3 == 1 && (x * 3 + k) % 7 == 5)
                cycle(0, 0, 0, 0, 0, 0, 0, 0, k - 1, x);
            ev = (k >= 1);
            ed = 0; ek = 0;
            if (ev) begin
                expect_px(p, x, ed, ek);
                if (ek == 0) n_edge++;
                else if (ek == 1) n_agree++;
                else n_fill++;
            end
            // R3: mirrored left stream
            cycle(1, x == 0, Rm[c][x], Lm[c][LW-1-x], ev, ev && x == 0, ed, ek, k - 1, x);
        end
        if (k % 4 == 2) begin
            cycle(0, 0, 0, 0, 0, 0, 0, 0, k, -1);
            cycle(0, 0, 0, 0, 0, 0, 0, 0, k, -1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        compared++;
        if (out_valid !== 1'b0 || out_sol !== 1'b0)
            fail_line("R1 reset", int'(out_valid) + 2 * int'(out_sol), 0, -1, -1);
        rst = 1'b0;
        @(negedge clk);
        compared++;
        if (out_valid !== 1'b0 || out_sol !== 1'b0)
            fail_line("R1 after reset", int'(out_valid) + 2 * int'(out_sol), 0, -1, -1);
        for (int k = 0; k <= NL; k++)
            send_line(k);
        for (int i = 0; i < 3; i++)
            cycle(0, 0, 0, 0, 0, 0, 0, 0, NL, -1);
        // each decision path was exercised
        compared++;
        if (n_edge == 0) fail_line("R7 coverage", n_edge, 1, -1, -1);
        compared++;
        if (n_agree == 0) fail_line("R5 coverage", n_agree, 1, -1, -1);
        compared++;
        if (n_fill == 0) fail_line("R6 coverage", n_fill, 1, -1, -1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule